// File: doc/BRIEF.md
# Requester Wait-and-Retry Tracker

This block sits next to a cache line controller and follows one outstanding coherent request from the requester's side. When the command issue logic starts a read-shared, read-modified or invalidate, the tracker stores the command and the line address. It then reads the status attributes returned on that transaction. A plain completion resolves at once. A split status parks the request until the matching response arrives. A wait status holds it until some completion to the same line is snooped.

When the request is finished, the tracker pulses `done` with the coherence state to load into the line. A shared-response can satisfy a waiting read-shared by capturing its data, with no new bus transaction. Any other release of a wait pulses `retry_req`, and the command issue logic then reissues the held request. For split reads, the exclusive-versus-shared decision comes from whether other caches drove the transfer-flag attribute on the response.

Top module: `rqt_tracker`

## Requirements
- R1: After reset, `busy`, `done` and `retry_req` are 0.
- R2: A request with `issue_cmd` not 0 is accepted only when the tracker is idle, and `busy` rises on the next cycle. An issue made while busy has no effect: the held address and command stay unchanged. Command codes are 1 = read-shared, 2 = read-modified and 3 = invalidate.
- R3: If a status cycle has neither wait nor split set, `done` pulses on the next cycle. The `done_state` codes are 0 invalid, 1 shared-unmodified, 2 exclusive-unmodified and 3 exclusive-modified. A read-shared gives 2 without `stat_tf` and 1 with it. A read-modified or invalidate gives 3.
- R4: A split status (`stat_sr` without `stat_wt`) parks the request. A shared-response (`rsp_kind` 0) to the same line then completes a read-shared with state 2 if `rsp_tf` is 0, or state 1 if it is 1.
- R5: A parked read-modified or invalidate is completed with state 3 by a modified-response (`rsp_kind` 1) to the same line.
- R6: While parked, responses to another line are ignored, and so are responses of the wrong kind for the held command (a modified-response to a read-shared, or a shared-response to a read-modified or invalidate).
- R7: Wait takes priority over split: a status with `stat_wt` set holds the request even when `stat_sr` is also set.
- R8: While held by a wait, a shared-response to the same line finishes a held read-shared with state 1. In that case `retry_req` does not pulse.
- R9: While held by a wait, a modified-response to the same line, or a shared-response when the held command is read-modified or invalidate, pulses `retry_req` for one cycle with no `done`. The tracker then awaits the status of the reissued request.
- R10: Two addresses refer to the same line when they are equal above the lowest `LINE_OFS` (4) bits. The offset bits are not compared.
- R11: Each request returns to idle (`busy` 0) in the same cycle that `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_cmd | input | 2 | New request command (0 = none) |
| issue_addr | input | ADDR_W | Address of the new request |
| stat_valid | input | 1 | Status phase of the own transaction |
| stat_wt | input | 1 | Wait attribute on own transaction |
| stat_sr | input | 1 | Split attribute on own transaction |
| stat_tf | input | 1 | Transfer flag from other caches on own transaction |
| rsp_valid | input | 1 | A response transaction is snooped |
| rsp_kind | input | 1 | 0 shared-response, 1 modified-response |
| rsp_addr | input | ADDR_W | Address of the snooped response |
| rsp_tf | input | 1 | Transfer flag from other caches on the response |
| busy | output | 1 | A request is outstanding |
| done | output | 1 | One-cycle completion pulse |
| done_state | output | 2 | Final line state, valid with done |
| retry_req | output | 1 | One-cycle reissue request |
| retry_cmd | output | 2 | Held command to reissue |
| retry_addr | output | ADDR_W | Held address to reissue |

## Verification
All results are registered. `done`, `done_state` and `retry_req` therefore appear exactly one cycle after the clock edge that samples the status or the response. `busy` follows one cycle after an accepted issue. The bench drives every stimulus at the falling edge and holds it for one full cycle. It samples at the next falling edge, where the pulse must be present, and checks at the falling edge after that that the pulse is gone. This ties each check to the single cycle in which the result is due.

// File: rtl/rqt_pkg.sv
package rqt_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_RD_SH  = 2'd1,
        CMD_RD_MOD = 2'd2,
        CMD_INVAL  = 2'd3
    } req_cmd_e;

    typedef enum logic [1:0] {
        LN_INVALID    = 2'd0,
        LN_SH_CLEAN   = 2'd1,
        LN_EXCL_CLEAN = 2'd2,
        LN_EXCL_DIRTY = 2'd3
    } line_state_e;

    typedef enum logic [2:0] {
        TS_IDLE   = 3'd0,
        TS_ISSUED = 3'd1,
        TS_SPLIT  = 3'd2,
        TS_WAIT   = 3'd3,
        TS_RETRY  = 3'd4
    } trk_state_e;

    localparam logic RSP_SHARED = 1'b0;
    localparam logic RSP_MOD    = 1'b1;

    function automatic logic wants_shared(req_cmd_e c);
        return c == CMD_RD_SH;
    endfunction

endpackage

// File: rtl/rqt_hold.sv
module rqt_hold
    import rqt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  req_cmd_e          cmd_in,
    input  logic [ADDR_W-1:0] addr_in,
    output req_cmd_e          cmd_q,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NONE;
            addr_q <= '0;
        end else if (load) begin
            cmd_q  <= cmd_in;
            addr_q <= addr_in;
        end
    end
endmodule

// File: rtl/rqt_match.sv
module rqt_match #(
    parameter int ADDR_W   = 16,
    parameter int LINE_OFS = 4
) (
    input  logic [ADDR_W-1:0] held_addr,
    input  logic [ADDR_W-1:0] seen_addr,
    output logic              same_line
);
    localparam int TAG_W = ADDR_W - LINE_OFS;

    logic [TAG_W-1:0] held_tag;
    logic [TAG_W-1:0] seen_tag;

    assign held_tag  = held_addr[ADDR_W-1:LINE_OFS];
    assign seen_tag  = seen_addr[ADDR_W-1:LINE_OFS];
    assign same_line = (held_tag == seen_tag);
endmodule

// File: rtl/rqt_resolve.sv
module rqt_resolve
    import rqt_pkg::*;
(
    input  req_cmd_e    cmd,
    input  logic        stat_tf,
    input  logic        rsp_kind,
    input  logic        rsp_tf,
    output line_state_e direct_state,
    output logic        rsp_completes,
    output line_state_e rsp_state,
    output logic        wait_snarf
);
    always_comb begin
        if (wants_shared(cmd)) begin
            direct_state  = stat_tf ? LN_SH_CLEAN : LN_EXCL_CLEAN;
            rsp_completes = (rsp_kind == RSP_SHARED);
            rsp_state     = rsp_tf ? LN_SH_CLEAN : LN_EXCL_CLEAN;
            wait_snarf    = (rsp_kind == RSP_SHARED);
        end else begin
            direct_state  = LN_EXCL_DIRTY;
            rsp_completes = (rsp_kind == RSP_MOD);
            rsp_state     = LN_EXCL_DIRTY;
            wait_snarf    = 1'b0;
        end
    end
endmodule

// File: rtl/rqt_tracker.sv
module rqt_tracker
    import rqt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LINE_OFS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        issue_cmd,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              stat_valid,
    input  logic              stat_wt,
    input  logic              stat_sr,
    input  logic              stat_tf,
    input  logic              rsp_valid,
    input  logic              rsp_kind,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic              rsp_tf,
    output logic              busy,
    output logic              done,
    output logic [1:0]        done_state,
    output logic              retry_req,
    output logic [1:0]        retry_cmd,
    output logic [ADDR_W-1:0] retry_addr
);
    trk_state_e        st_q, st_d;
    req_cmd_e          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              load;
    logic              hit;
    line_state_e       direct_state, rsp_state, fin_d;
    logic              rsp_completes, wait_snarf;
    logic              done_d;
    logic              done_q;
    line_state_e       fin_q;

    assign load = (st_q == TS_IDLE) && (issue_cmd != 2'd0);

    rqt_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cmd_in (req_cmd_e'(issue_cmd)),
        .addr_in(issue_addr),
        .cmd_q  (cmd_q),
        .addr_q (addr_q)
    );

    rqt_match #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) u_match (
        .held_addr(addr_q),
        .seen_addr(rsp_addr),
        .same_line(hit)
    );

    rqt_resolve u_resolve (
        .cmd          (cmd_q),
        .stat_tf      (stat_tf),
        .rsp_kind     (rsp_kind),
        .rsp_tf       (rsp_tf),
        .direct_state (direct_state),
        .rsp_completes(rsp_completes),
        .rsp_state    (rsp_state),
        .wait_snarf   (wait_snarf)
    );

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        fin_d  = LN_INVALID;
        unique case (st_q)
            TS_IDLE: if (load) st_d = TS_ISSUED;
            TS_ISSUED: begin
                if (stat_valid) begin
                    if (stat_wt)      st_d = TS_WAIT;
                    else if (stat_sr) st_d = TS_SPLIT;
                    else begin
                        st_d   = TS_IDLE;
                        done_d = 1'b1;
                        fin_d  = direct_state;
                    end
                end
            end
            TS_SPLIT: begin
                if (rsp_valid && hit && rsp_completes) begin
                    st_d   = TS_IDLE;
                    done_d = 1'b1;
                    fin_d  = rsp_state;
                end
            end
            TS_WAIT: begin
                if (rsp_valid && hit) begin
                    if (wait_snarf) begin
                        st_d   = TS_IDLE;
                        done_d = 1'b1;
                        fin_d  = LN_SH_CLEAN;
                    end else begin
                        st_d = TS_RETRY;
                    end
                end
            end
            TS_RETRY: st_d = TS_ISSUED;
            default:  st_d = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TS_IDLE;
            done_q <= 1'b0;
            fin_q  <= LN_INVALID;
        end else begin
            st_q   <= st_d;
            done_q <= done_d;
            fin_q  <= fin_d;
        end
    end

    assign busy       = (st_q != TS_IDLE);
    assign done       = done_q;
    assign done_state = fin_q;
    assign retry_req  = (st_q == TS_RETRY);
    assign retry_cmd  = cmd_q;
    assign retry_addr = addr_q;

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!done && !retry_req && !busy)); // R1
    AST_NO_DONE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) $past(st_q == TS_IDLE) |-> !done); // R2
    AST_DIRTY_NEEDS_MOD: assert property (@(posedge clk) disable iff (rst) (done && done_state == 2'd3) |-> (cmd_q != CMD_RD_SH)); // R5
    AST_SPLIT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst) (done && $past(st_q == TS_SPLIT)) |-> $past(rsp_valid && hit)); // R6
    AST_SNARF_SHARED: assert property (@(posedge clk) disable iff (rst) (done && $past(st_q == TS_WAIT)) |-> (done_state == 2'd1)); // R8
    AST_RETRY_FROM_WAIT: assert property (@(posedge clk) disable iff (rst) $rose(retry_req) |-> ($past(st_q == TS_WAIT) && !done)); // R9
    AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) retry_req |=> !retry_req); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R11
endmodule

// File: tb/sim_rqt_tracker.sv
module sim_rqt_tracker;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    issue_cmd = '0;
    logic [AW-1:0] issue_addr = '0;
    logic          stat_valid = 0, stat_wt = 0, stat_sr = 0, stat_tf = 0;
    logic          rsp_valid = 0, rsp_kind = 0, rsp_tf = 0;
    logic [AW-1:0] rsp_addr = '0;
    logic          busy, done, retry_req;
    logic [1:0]    done_state, retry_cmd;
    logic [AW-1:0] retry_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rqt_tracker #(.ADDR_W(AW), .LINE_OFS(4)) u0 (
        .clk(clk), .rst(rst), .issue_cmd(issue_cmd), .issue_addr(issue_addr),
        .stat_valid(stat_valid), .stat_wt(stat_wt), .stat_sr(stat_sr), .stat_tf(stat_tf),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr), .rsp_tf(rsp_tf),
        .busy(busy), .done(done), .done_state(done_state), .retry_req(retry_req),
        .retry_cmd(retry_cmd), .retry_addr(retry_addr)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int direct_exp(int cmd, int tf);
        if (cmd == 1) return tf ? 1 : 2;
        return 3;
    endfunction

    task automatic do_issue(int cmd, logic [AW-1:0] a);
        issue_cmd = 2'(cmd); issue_addr = a;
        @(negedge clk);
        issue_cmd = 0;
    endtask

    task automatic do_stat(logic wt, logic sr, logic tf);
        stat_valid = 1; stat_wt = wt; stat_sr = sr; stat_tf = tf;
        @(negedge clk);
        stat_valid = 0; stat_wt = 0; stat_sr = 0; stat_tf = 0;
    endtask

    task automatic do_rsp(logic kind, logic [AW-1:0] a, logic tf);
        rsp_valid = 1; rsp_kind = kind; rsp_addr = a; rsp_tf = tf;
        @(negedge clk);
        rsp_valid = 0; rsp_kind = 0; rsp_tf = 0;
    endtask

    task automatic expect_done(string tag, int st);
        chk({tag, " done"}, int'(done), 1);
        chk({tag, " state"}, int'(done_state), st);
        chk({tag, " R11 idle"}, int'(busy), 0);
        @(negedge clk);
        chk({tag, " done pulse width"}, int'(done), 0);
    endtask

    initial begin
        #5_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 retry", int'(retry_req), 0);

        for (int cmd = 1; cmd <= 3; cmd++) begin
            for (int tf = 0; tf <= 1; tf++) begin
                logic [AW-1:0] a;
                a = 16'(16'h1230 + cmd * 16'h100 + tf);
                // R2 / R3 direct completion
                do_issue(cmd, a);
                chk("R2 busy after issue", int'(busy), 1);
                chk("R2 retry_cmd held", int'(retry_cmd), cmd);
                do_stat(0, 0, tf[0]);
                expect_done("R3 direct", direct_exp(cmd, tf));

                // R4 / R5 split, with R6 ignored responses first
                do_issue(cmd, a);
                do_stat(0, 1, 0);
                chk("R4 split no done", int'(done), 0);
                do_rsp(cmd == 1 ? 1'b0 : 1'b1, a ^ 16'h0100, 0);
                chk("R6 other line ignored", int'(done), 0);
                chk("R6 still busy", int'(busy), 1);
                do_rsp(cmd == 1 ? 1'b1 : 1'b0, a, 0);
                chk("R6 wrong kind ignored", int'(done), 0);
                // R10 offset bits not compared
                do_rsp(cmd == 1 ? 1'b0 : 1'b1, a ^ 16'h000F, tf[0]);
                if (cmd == 1) expect_done("R4 split shared", tf ? 1 : 2);
                else          expect_done("R5 split modified", 3);

                // R7 wait over split, then R8 or R9
                do_issue(cmd, a);
                do_stat(1, 1, 0);
                chk("R7 wait no done", int'(done), 0);
                do_rsp(0, a ^ 16'h0200, 0);
                chk("R7 other line no release", int'(retry_req) + int'(done), 0);
                do_rsp(tf[0], a, 0);
                if (cmd == 1 && tf == 0) begin
                    chk("R8 no retry", int'(retry_req), 0);
                    expect_done("R8 snarf", 1);
                end else begin
                    chk("R9 retry pulse", int'(retry_req), 1);
                    chk("R9 no done", int'(done), 0);
                    chk("R9 retry addr", int'(retry_addr), int'(a));
                    @(negedge clk);
                    chk("R9 retry one cycle", int'(retry_req), 0);
                    chk("R9 still busy", int'(busy), 1);
                    do_stat(0, 0, 1);
                    expect_done("R9 reissued", direct_exp(cmd, 1));
                end
            end
        end

        // R2 issue while busy has no effect
        do_issue(2, 16'hA000);
        do_issue(1, 16'hB000);
        chk("R2 cmd unchanged", int'(retry_cmd), 2);
        chk("R2 addr unchanged", int'(retry_addr), 16'hA000);
        do_stat(0, 1, 0);
        do_rsp(1, 16'hB000, 0);
        chk("R2 second addr ignored", int'(done), 0);
        do_rsp(1, 16'hA004, 0);
        expect_done("R2 first request kept", 3);

        // R1 reset mid-request
        do_issue(1, 16'h4440);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R1 reset clears busy", int'(busy), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule